// File: doc/BRIEF.md
# NIC Interrupt Moderation Timers

This block sits between the receive and transmit paths of a network interface and the host interrupt line. Cause strobes from either path are latched into a pending cause register. The pending bits are gated by a mask, and a single level interrupt line is driven from a small state machine. A throttle interval, counted in units of 1024 ns, limits how often that line can rise. A post flagged urgent may cut the interval short.

Four delay timers moderate descriptor traffic:

- A receive packet timer and a transmit packet timer restart on every packet event.
- A receive absolute timer and a transmit absolute timer arm on the first packet event and then run to the end, ignoring later events.

When any timer expires, the block pulses the writeback request for its path. One cycle later it posts that path's cause: the receive-timer cause for receive timers and the transmit-writeback cause for transmit timers. A completed transmit descriptor writeback also posts the transmit-writeback cause. Software reads the cause register, and that read clears it.

The line state machine has three states:

- `ST_IDLE`: line low, no throttle interval running.
- `ST_ASSERT`: line high.
- `ST_HOLD`: line low while a throttle interval runs.

Its transitions are:

- **raise** (`ST_IDLE`→`ST_ASSERT`): taken when the masked pending set becomes non-empty.
- **drop-free** (`ST_ASSERT`→`ST_IDLE`): taken when the masked set empties and the interval is already over.
- **drop-held** (`ST_ASSERT`→`ST_HOLD`): taken when the masked set empties while the interval still runs.
- **release** (`ST_HOLD`→`ST_ASSERT`): taken when the interval ends with causes pending.
- **bypass** (`ST_HOLD`→`ST_ASSERT`): taken on an urgent post of an enabled cause.
- **expire** (`ST_HOLD`→`ST_IDLE`): taken when the interval ends with nothing pending.

Each entry into `ST_ASSERT` reloads the throttle interval.

Top module: `nic_irq_moderator`

## Requirements
- R1: After reset the cause register reads zero, the mask is all clear, and the interrupt line and both writeback requests are low.
- R2: A strobe on bit i of `cause_strobe_i` sets pending bit i, visible on `cause_o` after the next clock edge. Pending bits stay set until a read clears them.
- R3: A `cause_rd_i` pulse clears every pending bit at the next edge. A cause posted in that same cycle survives the clear. The line drops when nothing enabled remains.
- R4: Mask bits are set through `mask_set_i` and cleared through `mask_clr_i`; clear wins when both hit the same bit. A mask change re-evaluates the pending causes, so the line rises or falls at the next edge.
- R5: The receive packet timer reloads from `rx_pkt_dly_i` on every `rx_pkt_i`. It counts down once per delay unit of `DLY_DIV` clocks. On reaching zero it pulses `rx_wb_req_o` for one cycle, and the following cycle shows cause bit 1 (receive timer) pending. A reload that coincides with expiry wins.
- R6: The receive absolute timer loads from `rx_abs_dly_i` only on an `rx_pkt_i` that finds it idle. Events while it runs do not extend it. Its expiry behaves as in R5.
- R7: The transmit packet and transmit absolute timers behave as in R5 and R6, using `tx_pkt_i`, `tx_pkt_dly_i` and `tx_abs_dly_i`. They pulse `tx_wb_req_o` and post cause bit 0 (transmit writeback).
- R8: A `tx_wb_done_i` pulse sets cause bit 0 at the next edge.
- R9: A timer whose load value is zero when its event arrives stays idle and never fires.
- R10: Once the line rises, it cannot rise again until `throttle_i × THR_DIV` clocks after that rise; a zero throttle value means no interval. When causes are waiting as the interval ends, the line rises exactly that many clocks after the previous rise.
- R11: A post of an enabled cause with `urgent_i` high raises the line at the next edge, even during a throttle interval.
- R12: The line is high only while the pending and mask sets overlap. With no interval running, it rises at the same edge that makes them overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cause_strobe_i | input | NCAUSE | One-cycle cause posts, bit i posts cause i |
| urgent_i | input | 1 | Marks the posts on `cause_strobe_i` this cycle as urgent (bypass throttle) |
| rx_pkt_i | input | 1 | Receive packet event, starts receive timers |
| tx_pkt_i | input | 1 | Transmit packet event, starts transmit timers |
| tx_wb_done_i | input | 1 | Transmit descriptor writeback completed |
| rx_pkt_dly_i | input | DLY_W | Receive packet timer load, delay units |
| rx_abs_dly_i | input | DLY_W | Receive absolute timer load, delay units |
| tx_pkt_dly_i | input | DLY_W | Transmit packet timer load, delay units |
| tx_abs_dly_i | input | DLY_W | Transmit absolute timer load, delay units |
| throttle_i | input | THR_W | Throttle interval in 1024 ns units |
| mask_set_i | input | NCAUSE | Mask bits to enable |
| mask_clr_i | input | NCAUSE | Mask bits to disable |
| cause_rd_i | input | 1 | Cause register read, clears pending bits |
| cause_o | output | NCAUSE | Pending cause register |
| rx_wb_req_o | output | 1 | Receive descriptor writeback request pulse |
| tx_wb_req_o | output | 1 | Transmit descriptor writeback request pulse |
| irq_o | output | 1 | Interrupt line to the host |

## Verification
The assertions check several properties on every cycle:

- The line never stands high without an enabled pending cause.
- Every writeback request or completed writeback is followed by its cause bit.
- Pending bits only leave through a read.
- A plain read with no coinciding post empties the register.
- The line stays low while more than one throttle unit remains, unless an urgent post arrives.
- An urgent enabled post always raises the line.

Only the bench's scenarios show the exact expiry cycle of each timer. These include restart versus no-extension under a second event, and the reload-beats-expiry collision. The bench also shows the exact rise cycle after a throttle interval of each length, and the full cause-by-mask gating table.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ASSERT = 2'd1,
        ST_HOLD   = 2'd2
    } line_state_e;

    // Cause positions that the timers and writeback completion post into
    localparam int CAUSE_TXWB = 0;
    localparam int CAUSE_RXTM = 1;

    // Timer slots in the delay-timer array
    localparam int NTMR     = 4;
    localparam int TMR_RXPK = 0;
    localparam int TMR_RXAB = 1;
    localparam int TMR_TXPK = 2;
    localparam int TMR_TXAB = 3;

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int DIV = 256
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    output logic tick_o
);

    generate
        if (DIV <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk_i) begin
                if (!rst_ni || clr_i) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end

            assign tick_o = (cnt_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/dly_timer.sv
module dly_timer #(
    parameter int W       = 16,
    parameter bit RESTART = 1'b1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic         event_i,
    input  logic [W-1:0] load_i,
    output logic         fire_o
);

    logic [W-1:0] cnt_q;
    logic         fire_q;
    logic         start;

    // Restarting timers reload on every event; absolute ones only when idle
    assign start = event_i && (RESTART || (cnt_q == '0));

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            fire_q <= 1'b0;
        end else if (start) begin
            cnt_q  <= load_i;
            fire_q <= 1'b0;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_q  <= cnt_q - W'(1);
            fire_q <= (cnt_q == W'(1));
        end else begin
            fire_q <= 1'b0;
        end
    end

    assign fire_o = fire_q;

endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
    import nic_irq_pkg::*;
#(
    parameter int THR_W   = 10,
    parameter int THR_DIV = 256
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             has_cause_i,
    input  logic             urgent_hit_i,
    input  logic [THR_W-1:0] throttle_i,
    output logic             irq_o,
    output logic [THR_W-1:0] thr_left_o
);

    line_state_e      state_q, state_d;
    logic [THR_W-1:0] thr_q;
    logic             thr_tick;
    logic             expire;
    logic             enter;

    assign expire = (thr_q == '0) || ((thr_q == THR_W'(1)) && thr_tick);
    assign enter  = (state_d == ST_ASSERT) && (state_q != ST_ASSERT);

    tick_prescaler #(.DIV(THR_DIV)) u_thr_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (enter),
        .tick_o (thr_tick)
    );

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (has_cause_i) state_d = ST_ASSERT;               // raise
            end
            ST_ASSERT: begin
                if (!has_cause_i) state_d = expire ? ST_IDLE : ST_HOLD; // drop-free / drop-held
            end
            ST_HOLD: begin
                if (has_cause_i && (urgent_hit_i || expire)) begin
                    state_d = ST_ASSERT;                            // bypass / release
                end else if (expire) begin
                    state_d = ST_IDLE;                              // expire
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Throttle interval counter, reloaded on each rise of the line
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            thr_q <= '0;
        end else if (enter) begin
            thr_q <= throttle_i;
        end else if (thr_tick && (thr_q != '0)) begin
            thr_q <= thr_q - THR_W'(1);
        end
    end

    // Outputs
    always_comb begin
        irq_o      = (state_q == ST_ASSERT);
        thr_left_o = thr_q;
    end

endmodule

// File: rtl/nic_irq_moderator.sv
module nic_irq_moderator
    import nic_irq_pkg::*;
#(
    parameter int NCAUSE  = 4,
    parameter int DLY_W   = 16,
    parameter int THR_W   = 10,
    parameter int DLY_DIV = 256,
    parameter int THR_DIV = 256
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NCAUSE-1:0] cause_strobe_i,
    input  logic              urgent_i,
    input  logic              rx_pkt_i,
    input  logic              tx_pkt_i,
    input  logic              tx_wb_done_i,
    input  logic [DLY_W-1:0]  rx_pkt_dly_i,
    input  logic [DLY_W-1:0]  rx_abs_dly_i,
    input  logic [DLY_W-1:0]  tx_pkt_dly_i,
    input  logic [DLY_W-1:0]  tx_abs_dly_i,
    input  logic [THR_W-1:0]  throttle_i,
    input  logic [NCAUSE-1:0] mask_set_i,
    input  logic [NCAUSE-1:0] mask_clr_i,
    input  logic              cause_rd_i,
    output logic [NCAUSE-1:0] cause_o,
    output logic              rx_wb_req_o,
    output logic              tx_wb_req_o,
    output logic              irq_o
);

    logic [NCAUSE-1:0] pend_q, pend_d, mask_q, mask_d, post;
    logic [NTMR-1:0]   tmr_ev, tmr_fire;
    logic [DLY_W-1:0]  tmr_load [NTMR];
    logic              dly_tick;
    logic              has_cause, urgent_hit;
    logic [THR_W-1:0]  thr_left;

    tick_prescaler #(.DIV(DLY_DIV)) u_dly_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (1'b0),
        .tick_o (dly_tick)
    );

    always_comb begin
        tmr_ev             = '0;
        tmr_ev[TMR_RXPK]   = rx_pkt_i;
        tmr_ev[TMR_RXAB]   = rx_pkt_i;
        tmr_ev[TMR_TXPK]   = tx_pkt_i;
        tmr_ev[TMR_TXAB]   = tx_pkt_i;
        tmr_load[TMR_RXPK] = rx_pkt_dly_i;
        tmr_load[TMR_RXAB] = rx_abs_dly_i;
        tmr_load[TMR_TXPK] = tx_pkt_dly_i;
        tmr_load[TMR_TXAB] = tx_abs_dly_i;
    end

    // Even slots restart per packet, odd slots are absolute
    genvar g;
    generate
        for (g = 0; g < NTMR; g++) begin : g_tmr
            dly_timer #(.W(DLY_W), .RESTART((g % 2) == 0)) u_tmr (
                .clk_i   (clk_i),
                .rst_ni  (rst_ni),
                .tick_i  (dly_tick),
                .event_i (tmr_ev[g]),
                .load_i  (tmr_load[g]),
                .fire_o  (tmr_fire[g])
            );
        end
    endgenerate

    assign rx_wb_req_o = tmr_fire[TMR_RXPK] | tmr_fire[TMR_RXAB];
    assign tx_wb_req_o = tmr_fire[TMR_TXPK] | tmr_fire[TMR_TXAB];

    // Writeback request goes out first; its cause lands at the following edge
    always_comb begin
        post             = cause_strobe_i;
        post[CAUSE_TXWB] = post[CAUSE_TXWB] | tx_wb_req_o | tx_wb_done_i;
        post[CAUSE_RXTM] = post[CAUSE_RXTM] | rx_wb_req_o;
        pend_d           = (cause_rd_i ? '0 : pend_q) | post;
        mask_d           = (mask_q | mask_set_i) & ~mask_clr_i;
        has_cause        = |(pend_d & mask_d);
        urgent_hit       = urgent_i && |(cause_strobe_i & mask_d);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pend_q <= '0;
            mask_q <= '0;
        end else begin
            pend_q <= pend_d;
            mask_q <= mask_d;
        end
    end

    assign cause_o = pend_q;

    irq_line_fsm #(.THR_W(THR_W), .THR_DIV(THR_DIV)) u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .has_cause_i  (has_cause),
        .urgent_hit_i (urgent_hit),
        .throttle_i   (throttle_i),
        .irq_o        (irq_o),
        .thr_left_o   (thr_left)
    );

endmodule

// File: rtl/nic_irq_checker.sv
module nic_irq_checker #(
    parameter int NC    = 4,
    parameter int THR_W = 10
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             irq_o,
    input logic [NC-1:0]    cause_o,
    input logic [NC-1:0]    mask_q,
    input logic             cause_rd_i,
    input logic [NC-1:0]    cause_strobe_i,
    input logic             urgent_i,
    input logic [NC-1:0]    mask_clr_i,
    input logic             tx_wb_done_i,
    input logic             rx_wb_req_o,
    input logic             tx_wb_req_o,
    input logic [THR_W-1:0] thr_left
);

    assert_line_needs_cause_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ((cause_o & mask_q) != '0));

    assert_rx_wb_then_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_wb_req_o |=> cause_o[1]);

    assert_tx_wb_then_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_wb_req_o |=> cause_o[0]);

    assert_wb_done_posts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_wb_done_i |=> cause_o[0]);

    assert_pending_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cause_rd_i |=> ((cause_o & $past(cause_o)) == $past(cause_o)));

    assert_read_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cause_rd_i && (cause_strobe_i == '0) && !tx_wb_done_i && !rx_wb_req_o && !tx_wb_req_o)
        |=> (cause_o == '0));

    assert_throttle_gap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!irq_o && (thr_left > THR_W'(1)) && !urgent_i) |=> !irq_o);

    assert_urgent_bypass_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (urgent_i && ((cause_strobe_i & mask_q & ~mask_clr_i) != '0)) |=> irq_o);

endmodule

bind nic_irq_moderator nic_irq_checker #(.NC(NCAUSE), .THR_W(THR_W)) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .irq_o          (irq_o),
    .cause_o        (cause_o),
    .mask_q         (mask_q),
    .cause_rd_i     (cause_rd_i),
    .cause_strobe_i (cause_strobe_i),
    .urgent_i       (urgent_i),
    .mask_clr_i     (mask_clr_i),
    .tx_wb_done_i   (tx_wb_done_i),
    .rx_wb_req_o    (rx_wb_req_o),
    .tx_wb_req_o    (tx_wb_req_o),
    .thr_left       (thr_left)
);

// File: tb/test_nic_irq_moderator.sv
module test_nic_irq_moderator;

    localparam int CLK_PERIOD = 10;
    localparam int NC   = 4;
    localparam int DW   = 8;
    localparam int TW   = 6;
    localparam int TDIV = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] strobe = '0, mset = '0, mclr = '0;
    logic          urgent = 1'b0, rx_pkt = 1'b0, tx_pkt = 1'b0, wb_done = 1'b0, rd = 1'b0;
    logic [DW-1:0] ld_rp = '0, ld_ra = '0, ld_tp = '0, ld_ta = '0;
    logic [TW-1:0] thr = '0;
    logic [NC-1:0] cause;
    logic          rx_wb, tx_wb, irq;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nic_irq_moderator #(
        .NCAUSE(NC), .DLY_W(DW), .THR_W(TW), .DLY_DIV(1), .THR_DIV(TDIV)
    ) i_nic_irq_moderator (
        .clk_i(clk), .rst_ni(rst_n), .cause_strobe_i(strobe), .urgent_i(urgent),
        .rx_pkt_i(rx_pkt), .tx_pkt_i(tx_pkt), .tx_wb_done_i(wb_done),
        .rx_pkt_dly_i(ld_rp), .rx_abs_dly_i(ld_ra), .tx_pkt_dly_i(ld_tp), .tx_abs_dly_i(ld_ta),
        .throttle_i(thr), .mask_set_i(mset), .mask_clr_i(mclr), .cause_rd_i(rd),
        .cause_o(cause), .rx_wb_req_o(rx_wb), .tx_wb_req_o(tx_wb), .irq_o(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_all();
        rd = 1'b1; mclr = '1; thr = '0;
        step();
        rd = 1'b0; mclr = '0;
        repeat (40) step();
    endtask

    // sel: 0 rx packet, 1 rx absolute, 2 tx packet, 3 tx absolute
    task automatic run_timer(input int sel, input int l);
        int first;
        bit is_rx, is_abs;
        is_rx  = (sel < 2);
        is_abs = (sel % 2) == 1;
        clear_all();
        ld_rp = (sel == 0) ? DW'(l) : '0;
        ld_ra = (sel == 1) ? DW'(l) : '0;
        ld_tp = (sel == 2) ? DW'(l) : '0;
        ld_ta = (sel == 3) ? DW'(l) : '0;
        first = (l == 1) ? 1 : (is_abs ? l : l + 2);
        if (is_rx) rx_pkt = 1'b1; else tx_pkt = 1'b1;
        step();
        for (int n = 0; n <= l + 5; n++) begin
            int exp_wb;
            if (l == 1) exp_wb = (n == 1 || n == 3) ? 1 : 0;
            else exp_wb = (n == first) ? 1 : 0;
            if (is_rx) begin
                chk(is_abs ? "R6 rx abs wb_req" : "R5 rx pkt wb_req", int'(rx_wb), exp_wb);
                chk("R5 tx idle during rx test", int'(tx_wb), 0);
                chk(is_abs ? "R6 rx abs cause1" : "R5 rx pkt cause1", int'(cause[1]), (n > first) ? 1 : 0);
            end else begin
                chk("R7 tx wb_req", int'(tx_wb), exp_wb);
                chk("R7 rx idle during tx test", int'(rx_wb), 0);
                chk("R7 tx cause0", int'(cause[0]), (n > first) ? 1 : 0);
            end
            if (is_rx) rx_pkt = (n == 1); else tx_pkt = (n == 1);
            step();
        end
        rx_pkt = 1'b0; tx_pkt = 1'b0;
        ld_rp = '0; ld_ra = '0; ld_tp = '0; ld_ta = '0;
    endtask

    task automatic run_throttle(input int t, input bit urg);
        clear_all();
        thr = TW'(t);
        mset = '1;
        step();
        mset = '0;
        strobe = 4'b0100;
        step();
        strobe = '0;
        chk(urg ? "R11 first rise" : "R10 first rise", int'(irq), 1);
        rd = 1'b1;
        step();
        rd = 1'b0;
        for (int n = 1; n <= t * TDIV + 2; n++) begin
            int exp_irq;
            if (n == 1) exp_irq = 0;
            else if (urg) exp_irq = 1;
            else exp_irq = (n >= t * TDIV) ? 1 : 0;
            chk(urg ? "R11 urgent bypass" : "R10 throttle gap", int'(irq), exp_irq);
            strobe = (n == 1) ? 4'b1000 : '0;
            urgent = (n == 1) ? urg : 1'b0;
            step();
        end
        strobe = '0; urgent = 1'b0;
    endtask

    initial begin
        repeat (CLK_PERIOD * 150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) step();
        chk("R1 reset cause", int'(cause), 0);
        chk("R1 reset irq", int'(irq), 0);
        chk("R1 reset rx_wb", int'(rx_wb), 0);
        chk("R1 reset tx_wb", int'(tx_wb), 0);
        rst_n = 1'b1;
        step();
        chk("R1 after reset cause", int'(cause), 0);
        chk("R1 after reset irq", int'(irq), 0);
        // mask starts clear: a post must not raise the line
        strobe = 4'b1111;
        step();
        strobe = '0;
        chk("R1 mask clear after reset", int'(irq), 0);

        // R2 R12: every cause pattern against every mask pattern, no throttle
        for (int c = 0; c < 16; c++) begin
            for (int m = 0; m < 16; m++) begin
                rd = 1'b1; mclr = '1;
                step();
                rd = 1'b0; mclr = '0;
                chk("R3 line low after read", int'(irq), 0);
                mset = NC'(m); strobe = NC'(c);
                step();
                mset = '0; strobe = '0;
                chk("R2 cause latched", int'(cause), c);
                chk("R12 gated line", int'(irq), ((c & m) != 0) ? 1 : 0);
            end
        end

        // R4: mask writes re-evaluate
        clear_all();
        strobe = 4'b0011;
        step();
        strobe = '0;
        chk("R4 masked off", int'(irq), 0);
        mset = 4'b0010;
        step();
        mset = '0;
        chk("R4 set re-evaluates", int'(irq), 1);
        mset = 4'b0001; mclr = 4'b0011;
        step();
        mset = '0; mclr = '0;
        chk("R4 clear wins and drops line", int'(irq), 0);
        chk("R2 pending kept over mask change", int'(cause), 3);

        // R3: read with a coinciding post
        mset = 4'b0100;
        step();
        mset = '0;
        rd = 1'b1; strobe = 4'b0100;
        step();
        rd = 1'b0; strobe = '0;
        chk("R3 post survives read", int'(cause), 4);
        chk("R3 line kept by surviving cause", int'(irq), 1);
        rd = 1'b1;
        step();
        rd = 1'b0;
        chk("R3 read clears", int'(cause), 0);
        chk("R3 line drops", int'(irq), 0);

        // R8
        clear_all();
        wb_done = 1'b1;
        step();
        wb_done = 1'b0;
        chk("R8 writeback done posts cause0", int'(cause), 1);

        // R5 R6 R7: each timer over a sweep of load values
        for (int s = 0; s < 4; s++) begin
            for (int l = 1; l <= 6; l++) begin
                run_timer(s, l);
            end
        end

        // R9: zero loads disable every timer
        clear_all();
        rx_pkt = 1'b1; tx_pkt = 1'b1;
        step();
        rx_pkt = 1'b0; tx_pkt = 1'b0;
        for (int n = 0; n < 10; n++) begin
            chk("R9 disabled rx", int'(rx_wb), 0);
            chk("R9 disabled tx", int'(tx_wb), 0);
            step();
        end
        chk("R9 no cause", int'(cause), 0);

        // R10 R11
        for (int t = 1; t <= 4; t++) begin
            run_throttle(t, 1'b0);
            run_throttle(t, 1'b1);
        end

        clear_all();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule